// File: doc/BRIEF.md
# Memory-Mapped Character Terminal

This block is a small text console that a processor drives through seven byte-wide ports, starting at a parameter base address. Behind the ports is a character frame buffer of COLS by ROWS cells and a cursor. Software can clear the screen and print characters. One port interprets carriage return, line feed and backspace. Another stores every byte as a glyph. A third prints a byte as two hexadecimal digits. The cursor column and row can be read and set directly. When text runs off the bottom row, the screen scrolls up by one line.

Keystrokes enter through a valid/byte push interface into a small receive queue. The processor polls the queue through a read port that never blocks and returns zero when nothing is waiting. A display-side lookup port returns the glyph stored at any cell. Video timing and font rendering sit outside the block and use that port.

The frame buffer accepts one cell write per cycle. Clearing and scrolling therefore walk the buffer cell by cell. During the walk `busy` is high, and bus writes presented while `busy` is high are discarded. Software, or the bus master, waits for `busy` to fall before it writes again.

Top module: `txtterm`

## Requirements
- R1: The ports occupy BASE_ADDR+0 to BASE_ADDR+6 (BASE_ADDR defaults to 16'hE000). A write to any other address changes nothing. A read of any other address returns 8'h00.
- R2: Any write to BASE_ADDR+0 sets every cell to 8'h20 and the cursor to column 0, row 0. `busy` rises on the cycle after the write and stays high for COLS*ROWS cycles.
- R3: Writing 8'h0D to BASE_ADDR+1 sets the cursor column to 0, leaves the row unchanged and stores no glyph.
- R4: Writing 8'h0A to BASE_ADDR+1 moves the cursor down one row and keeps its column. On the last row, this write scrolls the screen instead and the cursor stays on the last row.
- R5: Writing 8'h08 to BASE_ADDR+1 with the cursor column above 0 moves the cursor one column left and writes 8'h20 into the cell it lands on. At column 0 the write has no effect.
- R6: Every byte written to BASE_ADDR+2, and every byte other than 8'h0D, 8'h0A and 8'h08 written to BASE_ADDR+1, is stored at the cursor and the cursor advances one column. Advancing past column COLS-1 moves the cursor to column 0 of the next row. On the last row it scrolls instead.
- R7: A scroll moves each row up by one and fills the bottom row with 8'h20. It holds `busy` high for COLS*ROWS cycles.
- R8: A byte written to BASE_ADDR+3 is printed as two uppercase ASCII hex digits, high nibble first, in two successive cursor cells. `busy` is high for 1 cycle, plus COLS*ROWS cycles for each scroll the two digits cause.
- R9: BASE_ADDR+5 reads and writes the cursor column, and BASE_ADDR+6 reads and writes the cursor row. A written value above COLS-1 or ROWS-1 is clamped to that limit.
- R10: Bytes pushed on `kb_valid` enter a FIFO_DEPTH-entry queue, and a push while the queue is full is dropped. A read of BASE_ADDR+4 returns the oldest byte and removes it, or returns 8'h00 when the queue is empty. Only such a read removes a byte.
- R11: Reads of BASE_ADDR+0 to BASE_ADDR+3 return 8'h00. Writes to BASE_ADDR+4 are ignored. Any write presented while `busy` is high is ignored.
- R12: After reset, every cell holds 8'h20, the cursor is at column 0, row 0, the queue is empty and `busy` is low.
- R13: `disp_char` returns, in the same cycle, the glyph at cell (`disp_col`, `disp_row`). It returns 8'h00 for a cell outside the screen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | AW | Bus byte address |
| bus_wdata | input | 8 | Bus write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Read data, valid in the same cycle as `bus_rd` |
| busy | output | 1 | High while a clear, scroll or second hex digit is in progress |
| kb_valid | input | 1 | Keyboard byte push |
| kb_data | input | 8 | Keyboard byte |
| disp_col | input | 8 | Display lookup column |
| disp_row | input | 8 | Display lookup row |
| disp_char | output | 8 | Glyph at the looked-up cell |

## Verification
Cursor moves, clamped positions and queue pops take effect at the clock edge that samples the strobe. Read data is combinational, so the bench compares `bus_rdata` a little after the read strobe is driven and before that edge. A glyph written at an edge shows on `disp_char` from the next cycle. The exception is a second hex digit or a scroll, which complete only when `busy` falls: one cycle after a hex write, and COLS*ROWS cycles after each scroll or clear. The bench therefore predicts the `busy` level for every cycle and compares it at each falling edge. It scans the screen only once `busy` has fallen.

// File: rtl/txtterm_pkg.sv
package txtterm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_HEX2   = 2'd1,
        ST_SCROLL = 2'd2,
        ST_CLEAR  = 2'd3
    } term_state_e;

    localparam logic [7:0] CH_SPACE = 8'h20;
    localparam logic [7:0] CH_CR    = 8'h0D;
    localparam logic [7:0] CH_LF    = 8'h0A;
    localparam logic [7:0] CH_BS    = 8'h08;

    localparam logic [2:0] PORT_CLEAR  = 3'd0;
    localparam logic [2:0] PORT_COOKED = 3'd1;
    localparam logic [2:0] PORT_RAW    = 3'd2;
    localparam logic [2:0] PORT_HEX    = 3'd3;
    localparam logic [2:0] PORT_KEY    = 3'd4;
    localparam logic [2:0] PORT_COLX   = 3'd5;
    localparam logic [2:0] PORT_ROWY   = 3'd6;
    localparam logic [2:0] PORT_COUNT  = 3'd7;

endpackage

// File: rtl/txtterm_cells.sv
module txtterm_cells #(
    parameter int CELLS = 64,
    parameter int IW    = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [IW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [IW-1:0] ra_addr,
    output logic [7:0]    ra_data,
    input  logic [IW-1:0] rb_addr,
    output logic [7:0]    rb_data
);
    import txtterm_pkg::*;

    logic [7:0] cell_q [CELLS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < CELLS; i++) cell_q[i] <= CH_SPACE;
        end else begin
            for (int i = 0; i < CELLS; i++) begin
                if (we && waddr == IW'(i)) cell_q[i] <= wdata;
            end
        end
    end

    // Two lookups; an index past the last cell reads as zero.
    always_comb begin
        ra_data = 8'h00;
        rb_data = 8'h00;
        for (int i = 0; i < CELLS; i++) begin
            if (ra_addr == IW'(i)) ra_data = cell_q[i];
            if (rb_addr == IW'(i)) rb_data = cell_q[i];
        end
    end

endmodule

// File: rtl/txtterm_rxq.sv
module txtterm_rxq #(
    parameter int DEPTH = 4,
    parameter int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            push,
    input  logic [7:0]      push_data,
    input  logic            pop,
    output logic [7:0]      head,
    output logic [CNTW-1:0] count
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0]      slot_q [DEPTH];
    logic [PW-1:0]   wp_q, rp_q;
    logic [CNTW-1:0] cnt_q;
    logic            push_ok, pop_ok;

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign push_ok = push && (cnt_q != CNTW'(DEPTH));
    assign pop_ok  = pop && (cnt_q != '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) wp_q <= bump(wp_q);
            if (pop_ok)  rp_q <= bump(rp_q);
            cnt_q <= cnt_q + CNTW'(push_ok) - CNTW'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) slot_q[wp_q] <= push_data;
    end

    assign head  = slot_q[rp_q];
    assign count = cnt_q;

endmodule

// File: rtl/txtterm_hexenc.sv
module txtterm_hexenc (
    input  logic [7:0] value,
    output logic [7:0] hi_char,
    output logic [7:0] lo_char
);
    logic [7:0] digit [2];

    for (genvar g = 0; g < 2; g++) begin : g_nib
        logic [3:0] nib;
        assign nib      = value[g*4 +: 4];
        assign digit[g] = (nib < 4'd10) ? (8'h30 + {4'h0, nib})
                                        : (8'h37 + {4'h0, nib});
    end

    assign lo_char = digit[0];
    assign hi_char = digit[1];

endmodule

// File: rtl/txtterm.sv
module txtterm #(
    parameter int          AW         = 16,
    parameter logic [15:0] BASE_ADDR  = 16'hE000,
    parameter int          COLS       = 16,
    parameter int          ROWS       = 4,
    parameter int          FIFO_DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [7:0]    bus_wdata,
    input  logic          bus_wr,
    input  logic          bus_rd,
    output logic [7:0]    bus_rdata,
    output logic          busy,
    input  logic          kb_valid,
    input  logic [7:0]    kb_data,
    input  logic [7:0]    disp_col,
    input  logic [7:0]    disp_row,
    output logic [7:0]    disp_char
);
    import txtterm_pkg::*;

    localparam int CELLS = COLS * ROWS;
    localparam int CW    = (COLS > 1) ? $clog2(COLS) : 1;
    localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1;
    localparam int IW    = $clog2(2 * CELLS);
    localparam int CNTW  = $clog2(FIFO_DEPTH + 1);

    typedef struct packed {
        term_state_e   st;
        logic [CW-1:0] col;
        logic [RW-1:0] row;
        logic [IW-1:0] idx;
        logic          pend;
        logic [7:0]    pch;
    } term_regs_t;

    typedef struct packed {
        logic          scroll;
        logic [RW-1:0] row;
        logic [CW-1:0] col;
    } cur_step_t;

    term_regs_t      regs_d, regs_q;
    cur_step_t       step;
    logic [AW-1:0]   off_full;
    logic [2:0]      off;
    logic            hit, wr_take, key_rd, rx_pop;
    logic [IW-1:0]   cur_cell, rb_addr, ra_addr;
    logic            fb_we;
    logic [IW-1:0]   fb_waddr;
    logic [7:0]      fb_wdata, ra_data, rb_data;
    logic [7:0]      hex_hi, hex_lo, rx_head;
    logic [CNTW-1:0] rx_count;
    logic            disp_ok, is_ctrl;

    // Port decode (wrap-safe subtraction)
    assign off_full = bus_addr - AW'(BASE_ADDR);
    assign hit      = off_full < AW'(PORT_COUNT);
    assign off      = off_full[2:0];
    assign wr_take  = bus_wr && hit && (regs_q.st == ST_IDLE);
    assign key_rd   = bus_rd && hit && (off == PORT_KEY);
    assign rx_pop   = key_rd && (rx_count != '0);
    assign busy     = (regs_q.st != ST_IDLE);

    assign cur_cell = IW'(regs_q.row) * IW'(COLS) + IW'(regs_q.col);
    assign rb_addr  = regs_q.idx + IW'(COLS);
    assign is_ctrl  = (bus_wdata == CH_CR) || (bus_wdata == CH_LF) || (bus_wdata == CH_BS);

    // Cursor advance by one cell, with wrap and scroll request
    always_comb begin
        step.scroll = 1'b0;
        step.row    = regs_q.row;
        step.col    = regs_q.col + 1'b1;
        if (regs_q.col == CW'(COLS - 1)) begin
            step.col = '0;
            if (regs_q.row == RW'(ROWS - 1)) step.scroll = 1'b1;
            else                             step.row    = regs_q.row + 1'b1;
        end
    end

    always_comb begin
        regs_d   = regs_q;
        fb_we    = 1'b0;
        fb_waddr = cur_cell;
        fb_wdata = bus_wdata;
        case (regs_q.st)
            ST_IDLE: begin
                if (wr_take) begin
                    if (off == PORT_RAW || (off == PORT_COOKED && !is_ctrl)) begin
                        fb_we      = 1'b1;
                        regs_d.col = step.col;
                        regs_d.row = step.row;
                        regs_d.idx = '0;
                        if (step.scroll) regs_d.st = ST_SCROLL;
                    end else begin
                        case (off)
                            PORT_CLEAR: begin
                                regs_d.col = '0;
                                regs_d.row = '0;
                                regs_d.idx = '0;
                                regs_d.st  = ST_CLEAR;
                            end
                            PORT_COOKED: begin
                                if (bus_wdata == CH_CR) begin
                                    regs_d.col = '0;
                                end else if (bus_wdata == CH_LF) begin
                                    if (regs_q.row == RW'(ROWS - 1)) begin
                                        regs_d.idx = '0;
                                        regs_d.st  = ST_SCROLL;
                                    end else begin
                                        regs_d.row = regs_q.row + 1'b1;
                                    end
                                end else if (regs_q.col != '0) begin
                                    regs_d.col = regs_q.col - 1'b1;
                                    fb_we      = 1'b1;
                                    fb_waddr   = cur_cell - 1'b1;
                                    fb_wdata   = CH_SPACE;
                                end
                            end
                            PORT_HEX: begin
                                fb_we       = 1'b1;
                                fb_wdata    = hex_hi;
                                regs_d.col  = step.col;
                                regs_d.row  = step.row;
                                regs_d.pend = 1'b1;
                                regs_d.pch  = hex_lo;
                                regs_d.idx  = '0;
                                regs_d.st   = step.scroll ? ST_SCROLL : ST_HEX2;
                            end
                            PORT_COLX: regs_d.col = (bus_wdata > 8'(COLS - 1)) ? CW'(COLS - 1)
                                                                             : bus_wdata[CW-1:0];
                            PORT_ROWY: regs_d.row = (bus_wdata > 8'(ROWS - 1)) ? RW'(ROWS - 1)
                                                                             : bus_wdata[RW-1:0];
                            default: ;
                        endcase
                    end
                end
            end
            ST_HEX2: begin
                fb_we       = 1'b1;
                fb_wdata    = regs_q.pch;
                regs_d.col  = step.col;
                regs_d.row  = step.row;
                regs_d.pend = 1'b0;
                regs_d.idx  = '0;
                regs_d.st   = step.scroll ? ST_SCROLL : ST_IDLE;
            end
            ST_SCROLL: begin
                fb_we      = 1'b1;
                fb_waddr   = regs_q.idx;
                fb_wdata   = (regs_q.idx < IW'(CELLS - COLS)) ? rb_data : CH_SPACE;
                regs_d.idx = regs_q.idx + 1'b1;
                if (regs_q.idx == IW'(CELLS - 1)) begin
                    regs_d.idx = '0;
                    regs_d.st  = regs_q.pend ? ST_HEX2 : ST_IDLE;
                end
            end
            ST_CLEAR: begin
                fb_we      = 1'b1;
                fb_waddr   = regs_q.idx;
                fb_wdata   = CH_SPACE;
                regs_d.idx = regs_q.idx + 1'b1;
                if (regs_q.idx == IW'(CELLS - 1)) begin
                    regs_d.idx = '0;
                    regs_d.st  = ST_IDLE;
                end
            end
            default: regs_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= '{st: ST_IDLE, col: '0, row: '0, idx: '0, pend: 1'b0, pch: 8'h00};
        end else begin
            regs_q <= regs_d;
        end
    end

    // Read data path
    always_comb begin
        bus_rdata = 8'h00;
        if (bus_rd && hit) begin
            case (off)
                PORT_KEY:  bus_rdata = (rx_count != '0) ? rx_head : 8'h00;
                PORT_COLX: bus_rdata = 8'(regs_q.col);
                PORT_ROWY: bus_rdata = 8'(regs_q.row);
                default:   bus_rdata = 8'h00;
            endcase
        end
    end

    // Display lookup
    assign disp_ok   = (disp_col < 8'(COLS)) && (disp_row < 8'(ROWS));
    assign ra_addr   = disp_ok ? IW'(32'(disp_row) * COLS + 32'(disp_col)) : '0;
    assign disp_char = disp_ok ? ra_data : 8'h00;

    txtterm_cells #(.CELLS(CELLS), .IW(IW)) cells_i (
        .clk(clk), .rst_n(rst_n), .we(fb_we), .waddr(fb_waddr), .wdata(fb_wdata),
        .ra_addr(ra_addr), .ra_data(ra_data), .rb_addr(rb_addr), .rb_data(rb_data)
    );

    txtterm_rxq #(.DEPTH(FIFO_DEPTH), .CNTW(CNTW)) rxq_i (
        .clk(clk), .rst_n(rst_n), .push(kb_valid), .push_data(kb_data),
        .pop(rx_pop), .head(rx_head), .count(rx_count)
    );

    txtterm_hexenc hexenc_i (.value(bus_wdata), .hi_char(hex_hi), .lo_char(hex_lo));

endmodule

// File: rtl/txtterm_chk.sv
module txtterm_chk #(
    parameter int COLS = 16,
    parameter int ROWS = 4
) (
    input logic       clk,
    input logic       rst_n,
    input logic       wr_take,
    input logic [2:0] wr_off,
    input logic [7:0] wr_data,
    input logic       busy,
    input logic [7:0] col,
    input logic [7:0] row,
    input logic       key_rd,
    input logic [7:0] rx_count,
    input logic [7:0] rdata
);
    a_r2_clear_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_take && wr_off == 3'd0) |=> (busy && col == 8'd0 && row == 8'd0));

    a_r8_hex_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_take && wr_off == 3'd3) |=> busy);

    a_r4_lf_last_row_scrolls: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_take && wr_off == 3'd1 && wr_data == 8'h0A && row == 8'(ROWS - 1))
        |=> (busy && row == 8'(ROWS - 1)));

    a_r9_cursor_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (col < 8'(COLS)) && (row < 8'(ROWS)));

    a_r10_pop_only_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !key_rd |=> (rx_count >= $past(rx_count)));

    a_r10_empty_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (key_rd && rx_count == 8'd0) |-> (rdata == 8'h00));

    a_r11_no_write_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !wr_take);

endmodule

bind txtterm txtterm_chk #(.COLS(COLS), .ROWS(ROWS)) chk_i (
    .clk(clk), .rst_n(rst_n), .wr_take(wr_take), .wr_off(off), .wr_data(bus_wdata),
    .busy(busy), .col(8'(regs_q.col)), .row(8'(regs_q.row)), .key_rd(key_rd),
    .rx_count(8'(rx_count)), .rdata(bus_rdata)
);

// File: tb/txtterm_tb_top.sv
module txtterm_tb_top;
    localparam int          COLS  = 16;
    localparam int          ROWS  = 4;
    localparam int          DEPTH = 4;
    localparam int          N     = COLS * ROWS;
    localparam logic [15:0] BASE  = 16'hE000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = 16'h0000;
    logic [7:0]  bus_wdata = 8'h00;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic        busy;
    logic        kb_valid = 1'b0;
    logic [7:0]  kb_data = 8'h00;
    logic [7:0]  disp_col = 8'h00, disp_row = 8'h00;
    logic [7:0]  disp_char;

    always #10 clk = ~clk;

    txtterm #(.AW(16), .BASE_ADDR(BASE), .COLS(COLS), .ROWS(ROWS), .FIFO_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .busy(busy),
        .kb_valid(kb_valid), .kb_data(kb_data), .disp_col(disp_col), .disp_row(disp_row),
        .disp_char(disp_char)
    );

    int total = 0, bad = 0;
    bit done = 1'b0;

    // Behavioural model
    int         scr [N];
    int         mcol = 0, mrow = 0, mbusy = 0;
    logic [7:0] mq [$];

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int hexch(input int v);
        return (v < 10) ? 48 + v : 55 + v;
    endfunction

    function void m_scroll();
        for (int i = 0; i < N - COLS; i++) scr[i] = scr[i + COLS];
        for (int i = N - COLS; i < N; i++) scr[i] = 32;
        mbusy += N;
    endfunction

    function void m_put(input int c);
        scr[mrow * COLS + mcol] = c;
        if (mcol == COLS - 1) begin
            mcol = 0;
            if (mrow == ROWS - 1) m_scroll();
            else mrow++;
        end else mcol++;
    endfunction

    function automatic int m_off(input logic [15:0] a);
        logic [15:0] o;
        o = a - BASE;
        return (o < 16'd7) ? int'(o) : -1;
    endfunction

    function automatic int m_read(input logic [15:0] a);
        case (m_off(a))
            4: return (mq.size() > 0) ? int'(mq[0]) : 0;
            5: return mcol;
            6: return mrow;
            default: return 0;
        endcase
    endfunction

    function void m_write(input int o, input int d);
        case (o)
            0: begin
                for (int i = 0; i < N; i++) scr[i] = 32;
                mcol = 0; mrow = 0; mbusy = N;
            end
            1: begin
                if (d == 8'h0D) mcol = 0;
                else if (d == 8'h0A) begin
                    if (mrow == ROWS - 1) m_scroll(); else mrow++;
                end else if (d == 8'h08) begin
                    if (mcol > 0) begin mcol--; scr[mrow * COLS + mcol] = 32; end
                end else m_put(d);
            end
            2: m_put(d);
            3: begin mbusy = 1; m_put(hexch(d / 16)); m_put(hexch(d % 16)); end
            5: mcol = (d > COLS - 1) ? COLS - 1 : d;
            6: mrow = (d > ROWS - 1) ? ROWS - 1 : d;
            default: ;
        endcase
    endfunction

    always @(posedge clk) begin
        if (rst_n) begin
            bit full;
            if (mbusy > 0) mbusy--;
            else if (bus_wr && m_off(bus_addr) >= 0) m_write(m_off(bus_addr), int'(bus_wdata));
            full = (mq.size() >= DEPTH);
            if (bus_rd && m_off(bus_addr) == 4 && mq.size() > 0) void'(mq.pop_front());
            if (kb_valid && !full) mq.push_back(kb_data);
        end
    end

    // busy level compared on every cycle (R2, R7, R8)
    always @(negedge clk) begin
        if (rst_n && !done) check("R7 busy level", int'(busy), int'(mbusy > 0));
    end

    task automatic wr_a(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic wr(input int o, input logic [7:0] d);
        wr_a(BASE + 16'(o), d);
    endtask

    task automatic rd_a(input logic [15:0] a, input string req);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #2;
        check(req, int'(bus_rdata), m_read(a));
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic rd(input int o, input string req);
        rd_a(BASE + 16'(o), req);
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic kb(input logic [7:0] d);
        @(negedge clk);
        kb_valid = 1'b1; kb_data = d;
        @(negedge clk);
        kb_valid = 1'b0;
    endtask

    task automatic screen(input string req);
        wait_idle();
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                @(negedge clk);
                disp_col = 8'(c); disp_row = 8'(r);
                #2;
                check(req, int'(disp_char), scr[r * COLS + c]);
            end
        end
    endtask

    initial begin
        for (int i = 0; i < N; i++) scr[i] = 32;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12 reset state
        rd(5, "R12 reset column");
        rd(6, "R12 reset row");
        rd(4, "R12 reset queue empty");
        screen("R12 reset screen");

        // R6 raw output, R13 display lookup
        wr(2, "A"); wr(2, "B");
        screen("R13 display after raw");
        rd(5, "R6 column after two glyphs");

        // R3, R5, R4 interpreted output
        wr(1, "H");
        wr(1, 8'h0D);
        rd(5, "R3 carriage return column");
        wr(1, 8'h08);
        rd(5, "R5 backspace at column 0");
        wr(1, 8'h0A);
        rd(6, "R4 line feed row");
        rd(5, "R4 line feed keeps column");
        wr(1, "x"); wr(1, "y"); wr(1, 8'h08);
        rd(5, "R5 backspace column");
        screen("R5 backspace blanks cell");

        // R6 control byte stored raw
        wr(2, 8'h0A);
        screen("R6 raw control glyph");

        // R8 hex print
        wr(3, 8'h3C); wait_idle();
        wr(3, 8'hA5); wait_idle();
        screen("R8 hex digits");
        rd(5, "R8 column after hex");

        // R9 clamp
        wr(5, 8'd200); wr(6, 8'd9);
        rd(5, "R9 column clamp");
        rd(6, "R9 row clamp");

        // R6 wrap into scroll, R7
        wr(2, "Z"); wait_idle();
        screen("R7 scroll after wrap");
        rd(5, "R6 wrap column");
        rd(6, "R7 row after scroll");

        // R4 line feed on last row
        wr(1, "q"); wr(1, 8'h0A); wait_idle();
        screen("R4 line feed scroll");

        // R11 write during busy ignored
        wr(1, 8'h0A);
        wr(2, "!");
        wait_idle();
        screen("R11 write while busy");
        rd(5, "R11 column after ignored write");

        // R8 hex whose high digit wraps and scrolls
        wr(5, 8'd15); wr(6, 8'd3);
        wr(3, 8'h7E); wait_idle();
        screen("R8 hex across scroll");
        rd(5, "R8 column after wrapped hex");

        // R11 write-only reads, read-only write
        for (int o = 0; o < 4; o++) rd(o, "R11 write-only port reads zero");
        wr(4, "k");
        rd(4, "R11 write to input port ignored");

        // R1 outside the window
        wr_a(BASE + 16'd7, "w");
        wr_a(BASE - 16'd1, "v");
        wr_a(16'h6002, "u");
        rd_a(BASE + 16'd7, "R1 read outside window");
        rd_a(16'h6005, "R1 read far outside window");
        rd(5, "R1 column unchanged");
        screen("R1 screen unchanged");

        // R10 input queue with overflow
        kb(8'h11); kb(8'h22); kb(8'h33); kb(8'h44); kb(8'h55);
        for (int k = 0; k < 5; k++) rd(4, "R10 queue read");
        kb(8'h66);
        rd(5, "R10 non-pop read");
        rd(4, "R10 queue after refill");

        // R2 clear
        wr(0, 8'h55);
        @(negedge clk);
        check("R2 busy after clear", int'(busy), 1);
        wait_idle();
        screen("R2 cleared screen");
        rd(5, "R2 column home");
        rd(6, "R2 row home");

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog R12 actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule